// File: doc/BRIEF.md
# Internal Data Memory Address Router

This block is the on-chip data-memory access unit of an 8-bit microcontroller core. Each cycle it accepts at most one request in one of three forms (a banked register operand, a direct byte address or an indirect byte address) and routes it to one of three physically separate 128-byte stores: the low RAM, the high RAM and the special-function-register (SFR) file. The address is always 8 bits wide. The top half of that address space reaches either the SFR file or the high RAM, and the form of the request decides which one.

Register operands are remapped through a bank selector held in the status byte. The status byte is itself an SFR, so a direct write to it changes the bank used by the next register access. Reads and writes take a single cycle. Each request is answered one clock later with `valid_o`, the returned byte and an error flag. Illegal requests return zero and change no storage. The high RAM can be removed by a parameter.

Top module: `idata_router`

## Requirements
- R1: While `rst_ni` is low and after reset, `valid_o`, `err_o` and `rdata_o` are 0 and the status byte is 00H, so register bank 0 is active. Reset does not clear RAM contents.
- R2: For both direct (`kind_i`=1) and indirect (`kind_i`=2) requests, addresses 00H–7FH reach the same low RAM byte.
- R3: A direct request at 80H–FFH reaches the SFR file. An indirect request at 80H–FFH reaches the high RAM and never the SFR file. The two stores hold independent values at the same address.
- R4: A register request (`kind_i`=0) reaches low RAM address bank*8 + `reg_idx_i`, where bank is bits 4:3 of the status byte.
- R5: The status byte lives at direct address D0H. A direct write to D0H sets the bank used by the next register request, and a direct read of D0H returns the byte last written there. An indirect access to D0H does not touch the status byte.
- R6: `valid_o` is high in the cycle after a cycle with `req_i` high, and low otherwise. `rdata_o` is 0 whenever `valid_o` is low.
- R7: A read in the cycle directly after a write to the same location returns the newly written byte.
- R8: With `HAS_UPPER`=0, an indirect request at 80H–FFH raises `err_o` with `valid_o`, returns 00H and writes nothing. The SFR and low RAM bytes are left unchanged.
- R9: A request with `kind_i`=3 raises `err_o`, returns 00H and writes nothing.
- R10: A legal write request returns the written byte on `rdata_o` with `err_o` low. A legal read returns the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| kind_i | input | 2 | Access form: 0 register, 1 direct, 2 indirect, 3 illegal |
| addr_i | input | 8 | Byte address for direct and indirect requests |
| reg_idx_i | input | 3 | Register number within the active bank |
| wr_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Returned byte, one cycle after the request |
| valid_o | output | 1 | Response strobe |
| err_o | output | 1 | Illegal request flag, qualified by `valid_o` |

## Verification
The hardest case to reach is a register request made right after the bank changes, when the bank was changed by a direct write to the status byte. Indirect traffic to the same D0H address must leave the bank alone. Random stimulus steers about one request in eight toward D0H, in both the direct and the indirect form, and mixes these with register requests. A reference model checks every response. A second instance built without high RAM is driven through directed sequences. These sequences confirm that rejected indirect writes leave the SFR byte and the low RAM byte at the same address untouched.

// File: rtl/idata_pkg.sv
package idata_pkg;
  typedef enum logic [1:0] {
    ACC_REG = 2'd0,
    ACC_DIR = 2'd1,
    ACC_IND = 2'd2,
    ACC_BAD = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    TGT_LOW  = 2'd0,
    TGT_UPP  = 2'd1,
    TGT_SFR  = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;
endpackage

// File: rtl/idata_route_dec.sv
module idata_route_dec
  import idata_pkg::*;
#(
  parameter int AW        = 8,
  parameter int BANK_W    = 2,
  parameter int IDX_W     = 3,
  parameter bit HAS_UPPER = 1'b1
) (
  input  logic [1:0]      kind_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [IDX_W-1:0] reg_idx_i,
  input  logic [BANK_W-1:0] bank_i,
  output tgt_e            tgt_o,
  output logic [AW-2:0]   idx_o,
  output logic            err_o
);
  localparam int HW = AW - 1;

  acc_kind_e kind;
  logic      high;

  assign kind = acc_kind_e'(kind_i);
  assign high = addr_i[AW-1];

  always_comb begin
    tgt_o = TGT_NONE;
    idx_o = addr_i[HW-1:0];
    err_o = 1'b0;
    unique case (kind)
      ACC_REG: begin
        tgt_o = TGT_LOW;
        idx_o = HW'({bank_i, reg_idx_i});
      end
      ACC_DIR: tgt_o = high ? TGT_SFR : TGT_LOW;
      ACC_IND: begin
        if (!high)          tgt_o = TGT_LOW;
        else if (HAS_UPPER) tgt_o = TGT_UPP;
        else                err_o = 1'b1;
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) mem[idx_i] <= wdata_i;
  end

  // write echoes the new byte; read returns stored byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (en_i) rdata_o <= we_i ? wdata_i : mem[idx_i];
  end
endmodule

// File: rtl/idata_sfr_file.sv
module idata_sfr_file #(
  parameter int DW       = 8,
  parameter int DEPTH    = 128,
  parameter int PSW_IDX  = 'h50,
  parameter int BANK_LSB = 3,
  parameter int BANK_W   = 2,
  localparam int IW      = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [BANK_W-1:0] bank_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] psw_q;
  logic          psw_hit;

  assign psw_hit = (idx_i == IW'(PSW_IDX));
  assign bank_o  = psw_q[BANK_LSB +: BANK_W];

  always_ff @(posedge clk_i) begin
    if (en_i && we_i && !psw_hit) mem[idx_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_q <= '0;
    end else if (en_i && we_i && psw_hit) begin
      psw_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (en_i) begin
      if (we_i)         rdata_o <= wdata_i;
      else if (psw_hit) rdata_o <= psw_q;
      else              rdata_o <= mem[idx_i];
    end
  end
endmodule

// File: rtl/idata_router.sv
module idata_router
  import idata_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AW         = 8,
  parameter int REG_BANKS  = 4,
  parameter int BANK_REGS  = 8,
  parameter int PSW_ADDR   = 'hD0,
  parameter int BANK_LSB   = 3,
  parameter bit HAS_UPPER  = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    kind_i,
  input  logic [7:0]    addr_i,
  input  logic [2:0]    reg_idx_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          valid_o,
  output logic          err_o
);
  localparam int HALF   = 2 ** (AW - 1);
  localparam int IW     = AW - 1;
  localparam int BANK_W = $clog2(REG_BANKS);
  localparam int IDX_W  = $clog2(BANK_REGS);

  tgt_e              tgt, tgt_q;
  logic [IW-1:0]     idx;
  logic              err;
  logic [BANK_W-1:0] bank;
  logic [DW-1:0]     low_rd, upp_rd, sfr_rd;
  logic              valid_q, err_q;
  logic              en_low, en_upp, en_sfr, we;

  idata_route_dec #(
    .AW(AW), .BANK_W(BANK_W), .IDX_W(IDX_W), .HAS_UPPER(HAS_UPPER)
  ) u_dec (
    .kind_i   (kind_i),
    .addr_i   (addr_i),
    .reg_idx_i(reg_idx_i),
    .bank_i   (bank),
    .tgt_o    (tgt),
    .idx_o    (idx),
    .err_o    (err)
  );

  assign we     = wr_i && !err;
  assign en_low = req_i && (tgt == TGT_LOW);
  assign en_upp = req_i && (tgt == TGT_UPP);
  assign en_sfr = req_i && (tgt == TGT_SFR);

  idata_ram #(.DW(DW), .DEPTH(HALF)) u_low (
    .clk_i, .rst_ni, .en_i(en_low), .we_i(we), .idx_i(idx),
    .wdata_i(wdata_i), .rdata_o(low_rd)
  );

  generate
    if (HAS_UPPER) begin : g_upper
      idata_ram #(.DW(DW), .DEPTH(HALF)) u_upp (
        .clk_i, .rst_ni, .en_i(en_upp), .we_i(we), .idx_i(idx),
        .wdata_i(wdata_i), .rdata_o(upp_rd)
      );
    end else begin : g_no_upper
      assign upp_rd = '0;
    end
  endgenerate

  idata_sfr_file #(
    .DW(DW), .DEPTH(HALF), .PSW_IDX(PSW_ADDR - HALF),
    .BANK_LSB(BANK_LSB), .BANK_W(BANK_W)
  ) u_sfr (
    .clk_i, .rst_ni, .en_i(en_sfr), .we_i(we), .idx_i(idx),
    .wdata_i(wdata_i), .rdata_o(sfr_rd), .bank_o(bank)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      tgt_q   <= TGT_NONE;
    end else begin
      valid_q <= req_i;
      err_q   <= req_i && err;
      tgt_q   <= req_i ? tgt : TGT_NONE;
    end
  end

  always_comb begin
    unique case (tgt_q)
      TGT_LOW: rdata_o = low_rd;
      TGT_UPP: rdata_o = upp_rd;
      TGT_SFR: rdata_o = sfr_rd;
      default: rdata_o = '0;
    endcase
  end

  assign valid_o = valid_q;
  assign err_o   = err_q;
endmodule

// File: rtl/idata_router_chk.sv
module idata_router_chk #(
  parameter bit HAS_UPPER = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic [1:0] kind_i,
  input logic [7:0] addr_i,
  input logic       wr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       valid_o,
  input logic       err_o
);
  logic legal;
  assign legal = (kind_i != 2'd3) && !(kind_i == 2'd2 && addr_i[7] && !HAS_UPPER);

  a_r6_valid_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  a_r6_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  a_r6_idle_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> rdata_o == 8'h00);
  a_r9_bad_kind_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i == 2'd3) |=> err_o);
  a_r8_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (valid_o && rdata_o == 8'h00));
  a_r3_direct_never_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i == 2'd1) |=> !err_o);
  a_r10_write_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wr_i && legal) |=> (!err_o && rdata_o == $past(wdata_i)));
endmodule

bind idata_router idata_router_chk #(.HAS_UPPER(HAS_UPPER)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .kind_i(kind_i),
  .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .valid_o(valid_o), .err_o(err_o)
);

// File: tb/sim_idata_router.sv
`timescale 1ns/1ps
module sim_idata_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req [2];
  logic [1:0] kind [2];
  logic [7:0] addr [2];
  logic [2:0] ridx [2];
  logic       wr [2];
  logic [7:0] wd [2];
  logic [7:0] rd [2];
  logic       vld [2];
  logic       er [2];

  int vectors = 0;
  int fails = 0;

  logic [7:0] m_low [128];
  logic [7:0] m_upp [128];
  logic [7:0] m_sfr [128];
  logic [7:0] m_psw;

  always #2.5 clk = ~clk;

  idata_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[0]), .kind_i(kind[0]), .addr_i(addr[0]),
    .reg_idx_i(ridx[0]), .wr_i(wr[0]), .wdata_i(wd[0]), .rdata_o(rd[0]),
    .valid_o(vld[0]), .err_o(er[0])
  );

  idata_router #(.HAS_UPPER(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[1]), .kind_i(kind[1]), .addr_i(addr[1]),
    .reg_idx_i(ridx[1]), .wr_i(wr[1]), .wdata_i(wd[1]), .rdata_o(rd[1]),
    .valid_o(vld[1]), .err_o(er[1])
  );

  task automatic check(input int u, input logic ev, input logic ee, input logic [7:0] ed,
                       input string tag);
    vectors++;
    if (vld[u] !== ev || er[u] !== ee || rd[u] !== ed) begin
      fails++;
      $display("FAIL %s u%0d: valid/err/data = %0b/%0b/%02h expected %0b/%0b/%02h",
               tag, u, vld[u], er[u], rd[u], ev, ee, ed);
    end
  endtask

  // apply one request at a negedge, sample at the following negedge
  task automatic op(input int u, input logic [1:0] k, input logic [7:0] a, input logic [2:0] ix,
                    input logic w, input logic [7:0] d, input logic ee, input logic [7:0] ed,
                    input string tag);
    req[u] = 1'b1; kind[u] = k; addr[u] = a; ridx[u] = ix; wr[u] = w; wd[u] = d;
    @(posedge clk); @(negedge clk);
    req[u] = 1'b0;
    check(u, 1'b1, ee, ed, tag);
  endtask

  // reference model for the full instance
  function automatic string tag_of(input logic [1:0] k, input logic [7:0] a);
    if (k == 2'd0) return "R4";
    if (k == 2'd3) return "R9";
    if (k == 2'd1 && a == 8'hD0) return "R5";
    if (a[7]) return "R3";
    return "R2";
  endfunction

  task automatic mop(input logic [1:0] k, input logic [7:0] a, input logic [2:0] ix,
                     input logic w, input logic [7:0] d);
    logic [7:0] exp_d;
    logic       exp_e;
    logic [6:0] li;
    exp_e = 1'b0;
    exp_d = 8'h00;
    li    = {m_psw[4:3], ix};
    case (k)
      2'd0: begin exp_d = w ? d : m_low[li]; if (w) m_low[li] = d; end
      2'd1: begin
        if (!a[7]) begin exp_d = w ? d : m_low[a[6:0]]; if (w) m_low[a[6:0]] = d; end
        else if (a == 8'hD0) begin exp_d = w ? d : m_psw; if (w) m_psw = d; end
        else begin exp_d = w ? d : m_sfr[a[6:0]]; if (w) m_sfr[a[6:0]] = d; end
      end
      2'd2: begin
        if (!a[7]) begin exp_d = w ? d : m_low[a[6:0]]; if (w) m_low[a[6:0]] = d; end
        else begin exp_d = w ? d : m_upp[a[6:0]]; if (w) m_upp[a[6:0]] = d; end
      end
      default: exp_e = 1'b1;
    endcase
    op(0, k, a, ix, w, d, exp_e, exp_d, tag_of(k, a));
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int u = 0; u < 2; u++) begin
      req[u] = 0; kind[u] = 0; addr[u] = 0; ridx[u] = 0; wr[u] = 0; wd[u] = 0;
    end
    m_psw = 8'h00;
    repeat (3) @(negedge clk);
    check(0, 1'b0, 1'b0, 8'h00, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(0, 1'b0, 1'b0, 8'h00, "R1 after reset");
    check(1, 1'b0, 1'b0, 8'h00, "R1 after reset u1");
    // R1: status byte cleared at reset
    op(0, 2'd1, 8'hD0, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00, "R1 psw reset");

    // fill every store so the model knows all contents
    for (int i = 0; i < 128; i++) mop(2'd1, 8'(i), 3'd0, 1'b1, 8'($urandom));
    for (int i = 128; i < 256; i++)
      if (i != 'hD0) mop(2'd1, 8'(i), 3'd0, 1'b1, 8'($urandom));
    for (int i = 128; i < 256; i++) mop(2'd2, 8'(i), 3'd0, 1'b1, 8'($urandom));

    // R3: same high address, different stores
    mop(2'd1, 8'hA5, 3'd0, 1'b1, 8'h11);
    mop(2'd2, 8'hA5, 3'd0, 1'b1, 8'h22);
    mop(2'd1, 8'hA5, 3'd0, 1'b0, 8'h00);
    mop(2'd2, 8'hA5, 3'd0, 1'b0, 8'h00);
    // R2: direct write, indirect read
    mop(2'd1, 8'h42, 3'd0, 1'b1, 8'h99);
    mop(2'd2, 8'h42, 3'd0, 1'b0, 8'h00);
    // R5/R4: bank switch then immediate register access in each bank
    for (int b = 0; b < 4; b++) begin
      mop(2'd1, 8'hD0, 3'd0, 1'b1, 8'(b << 3));
      mop(2'd0, 8'h00, 3'd5, 1'b1, 8'(8'hC0 + b));
      mop(2'd1, 8'(b * 8 + 5), 3'd0, 1'b0, 8'h00);
    end
    // R5: indirect D0 leaves bank alone
    mop(2'd2, 8'hD0, 3'd0, 1'b1, 8'h00);
    mop(2'd0, 8'h00, 3'd5, 1'b0, 8'h00);
    mop(2'd1, 8'hD0, 3'd0, 1'b0, 8'h00);
    // R7: write then immediate read
    mop(2'd2, 8'hF3, 3'd0, 1'b1, 8'h5E);
    mop(2'd2, 8'hF3, 3'd0, 1'b0, 8'h00);
    // R9: illegal kind, then confirm target unchanged
    mop(2'd3, 8'h42, 3'd0, 1'b1, 8'hEE);
    mop(2'd1, 8'h42, 3'd0, 1'b0, 8'h00);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] k;
      logic [7:0] a;
      k = 2'($urandom % 4);
      if ($urandom % 16 == 0) k = 2'd3;
      else if (k == 2'd3) k = 2'd0;
      a = 8'($urandom);
      if ($urandom % 8 == 0) a = 8'hD0;
      mop(k, a, 3'($urandom), 1'($urandom), 8'($urandom));
      if ($urandom % 10 == 0) begin
        @(negedge clk);
        check(0, 1'b0, 1'b0, 8'h00, "R6 idle");
      end
    end

    // instance without high RAM: R8
    op(1, 2'd1, 8'h90, 3'd0, 1'b1, 8'h5A, 1'b0, 8'h5A, "R10 u1 sfr write");
    op(1, 2'd1, 8'h10, 3'd0, 1'b1, 8'h33, 1'b0, 8'h33, "R10 u1 low write");
    op(1, 2'd2, 8'h90, 3'd0, 1'b1, 8'hFF, 1'b1, 8'h00, "R8 rejected write");
    op(1, 2'd2, 8'h90, 3'd0, 1'b0, 8'h00, 1'b1, 8'h00, "R8 rejected read");
    op(1, 2'd1, 8'h90, 3'd0, 1'b0, 8'h00, 1'b0, 8'h5A, "R8 sfr untouched");
    op(1, 2'd1, 8'h10, 3'd0, 1'b0, 8'h00, 1'b0, 8'h33, "R8 low untouched");
    op(1, 2'd2, 8'h10, 3'd0, 1'b0, 8'h00, 1'b0, 8'h33, "R2 u1 indirect low");
    op(1, 2'd3, 8'h10, 3'd0, 1'b1, 8'h77, 1'b1, 8'h00, "R9 u1 bad kind");
    op(1, 2'd1, 8'h10, 3'd0, 1'b0, 8'h00, 1'b0, 8'h33, "R9 u1 no write");

    // R1: reset keeps RAM, clears status byte
    mop(2'd1, 8'hD0, 3'd0, 1'b1, 8'h18);
    mop(2'd1, 8'h07, 3'd0, 1'b1, 8'h6C);
    rst_n = 1'b0;
    @(negedge clk);
    check(0, 1'b0, 1'b0, 8'h00, "R1 reset again");
    rst_n = 1'b1;
    m_psw = 8'h00;
    @(negedge clk);
    mop(2'd0, 8'h00, 3'd7, 1'b0, 8'h00);
    mop(2'd1, 8'hD0, 3'd0, 1'b0, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule